// File: doc/BRIEF.md
# Lens Command Repeater Mailbox

This block relays short commands from a host register port to a camera lens over a byte-wide link and collects whatever the lens sends back. The host loads four command bytes one after another through a setup register, then sets a start bit in the control register. The block streams the four bytes to the lens over a ready/valid byte channel, least significant byte first. It then waits for the reply.

Reply bytes arrive on a second ready/valid channel and are stored in a 63-entry FIFO. An end-of-reply strobe closes the exchange. The reply may hold any number of bytes, including none. The host polls the control register for a completion flag and a count of stored bytes. It then drains the reply one byte per read of the data register.

A start request or setup write made while an exchange is running is dropped, so a transfer in flight cannot be disturbed.

Top module: `lens_mbox`

## Requirements
- R1: After reset, the control register reads 0x00, reads of the data register return 0x00, and both `tx_valid` and `rx_ready` are low.
- R2: Each write to address 1 (setup) stores its byte in the next of four command slots, starting at slot 0. The slot pointer wraps from slot 3 back to slot 0, and it returns to slot 0 whenever a start request is accepted. Slots keep their contents until they are overwritten.
- R3: After a start request is accepted, slots 0 to 3 are sent in that order on `tx_data`, one per `tx_valid && tx_ready` cycle. Bytes written as 1, 2, 3, 4 therefore form the little-endian word 0x04030201. `tx_data` holds steady while `tx_ready` is low.
- R4: Reading address 0 returns {count[5:0], done, 0}: the reply byte count in bits 7:2, the completion flag in bit 1, and bit 0 always 0. Writing address 0 with bit 0 set is a start request. Address 3 reads 0x00.
- R5: An accepted start request clears the completion flag and discards all stored reply bytes, so the count becomes 0.
- R6: `rx_ready` is high only while the block is awaiting a reply and the FIFO holds fewer than 63 bytes. A byte offered while `rx_ready` is low is not stored.
- R7: `rx_end` while the block awaits a reply sets the completion flag and makes the block idle. A byte offered in the same cycle is stored. An empty reply leaves the count at 0.
- R8: A read of address 2 returns the oldest stored reply byte and removes it, which lowers the count by one. A read with no bytes stored returns 0x00 and leaves the count at 0.
- R9: While a command is being sent or a reply is awaited, start requests and setup writes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_rd | input | 1 | Host register read strobe (pops at address 2) |
| reg_addr | input | 2 | Register address: 0 control, 1 setup, 2 reply data |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Read data for the addressed register |
| tx_valid | output | 1 | Command byte valid toward the lens |
| tx_data | output | 8 | Command byte toward the lens |
| tx_ready | input | 1 | Lens accepts the command byte |
| rx_valid | input | 1 | Reply byte valid from the lens |
| rx_data | input | 8 | Reply byte from the lens |
| rx_end | input | 1 | End of reply strobe |
| rx_ready | output | 1 | Block accepts a reply byte |

## Verification
The send path is tested with distinct byte values and with a lens that stalls every other cycle, which exposes byte-order mistakes and any skipped or repeated byte. It is also tested with partial and overlong setup sequences, which separate a pointer that resets on start from one that merely wraps. Replies of zero, one, three and 64 offered bytes are used. These cases show the end strobe acting alone and acting together with the last byte, and they show the FIFO refusing bytes beyond 63. Start and setup writes are also made while a reply is pending, and bytes are offered while the block is idle. The first case shows whether dropped requests really leave the transfer and the slots untouched. The second shows whether the link input is ignored outside an exchange.

// File: rtl/lens_mbox_pkg.sv
package lens_mbox_pkg;

    localparam int BYTE_W   = 8;
    localparam int CMD_LEN  = 4;
    localparam int CNT_FLD  = 6;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_SETUP = 2'd1,
        SEL_DATA  = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        LNK_IDLE = 2'd0,
        LNK_SEND = 2'd1,
        LNK_WAIT = 2'd2
    } lnk_state_e;

    typedef struct packed {
        logic [CNT_FLD-1:0] count;
        logic               done;
        logic               go;
    } ctrl_view_t;

    function automatic logic [BYTE_W-1:0] pack_ctrl(input logic [CNT_FLD-1:0] cnt,
                                                    input logic done);
        ctrl_view_t v;
        v.count = cnt;
        v.done  = done;
        v.go    = 1'b0;
        return v;
    endfunction

endpackage

// File: rtl/lens_cmd_buf.sv
module lens_cmd_buf #(
    parameter int W     = 8,
    parameter int SLOTS = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         restart,
    input  logic         sending,
    input  logic         tx_ready,
    output logic         tx_valid,
    output logic [W-1:0] tx_data,
    output logic         last_taken
);
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SLOTS - 1);

    logic [W-1:0]     slot_q [SLOTS];
    logic [IDX_W-1:0] wptr_q;
    logic [IDX_W-1:0] tidx_q;
    logic             take;

    assign tx_valid   = sending;
    assign tx_data    = slot_q[tidx_q];
    assign take       = tx_valid && tx_ready;
    assign last_taken = take && (tidx_q == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr_q <= '0;
        end else if (restart) begin
            wptr_q <= '0;
        end else if (wr_en) begin
            wptr_q <= (wptr_q == LAST_IDX) ? '0 : wptr_q + 1'b1;
        end
    end

    generate
        for (genvar s = 0; s < SLOTS; s++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst) begin
                    slot_q[s] <= '0;
                end else if (wr_en && !restart && (wptr_q == IDX_W'(s))) begin
                    slot_q[s] <= wr_data;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            tidx_q <= '0;
        end else if (restart) begin
            tidx_q <= '0;
        end else if (take) begin
            tidx_q <= (tidx_q == LAST_IDX) ? '0 : tidx_q + 1'b1;
        end
    end

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data))) // R3
        else $error("tx byte changed while stalled");

endmodule

// File: rtl/lens_reply_fifo.sv
module lens_reply_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 63
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       flush,
    input  logic                       push,
    input  logic [W-1:0]               push_data,
    input  logic                       pop,
    output logic [W-1:0]               head,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full,
    output logic                       empty
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    logic [W-1:0]     mem_q [DEPTH];
    logic [PTR_W-1:0] wp_q, rp_q;
    logic [CNT_W-1:0] cnt_q;
    logic             do_push, do_pop;

    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign count   = cnt_q;
    assign head    = empty ? '0 : mem_q[rp_q];
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_ff @(posedge clk) begin
        if (do_push && !flush) begin
            mem_q[wp_q] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wp_q <= (wp_q == PTR_LAST) ? '0 : wp_q + 1'b1;
            if (do_pop)  rp_q <= (rp_q == PTR_LAST) ? '0 : rp_q + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        push |-> !full) // R6
        else $error("push offered to a full reply fifo");

    AST_POP_DEC: assert property (@(posedge clk) disable iff (rst)
        (pop && !empty && !push && !flush) |=> (count == $past(count) - 1'b1)) // R8
        else $error("pop did not lower the count");

endmodule

// File: rtl/lens_link_ctrl.sv
module lens_link_ctrl
    import lens_mbox_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic send_req,
    input  logic last_taken,
    input  logic rx_end,
    output logic send_accept,
    output logic busy,
    output logic sending,
    output logic waiting,
    output logic done
);
    lnk_state_e state_q, state_d;
    logic       done_q;

    assign send_accept = send_req && (state_q == LNK_IDLE);
    assign busy        = (state_q != LNK_IDLE);
    assign sending     = (state_q == LNK_SEND);
    assign waiting     = (state_q == LNK_WAIT);
    assign done        = done_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LNK_IDLE: if (send_req)   state_d = LNK_SEND;
            LNK_SEND: if (last_taken) state_d = LNK_WAIT;
            LNK_WAIT: if (rx_end)     state_d = LNK_IDLE;
            default:                  state_d = LNK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LNK_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (send_accept) begin
                done_q <= 1'b0;
            end else if (waiting && rx_end) begin
                done_q <= 1'b1;
            end
        end
    end

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy) // R7
        else $error("completion flag set during a transfer");

    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst)
        (waiting && send_req && !rx_end) |=> waiting) // R9
        else $error("start request disturbed a pending reply");

endmodule

// File: rtl/lens_mbox.sv
module lens_mbox
    import lens_mbox_pkg::*;
#(
    parameter int FIFO_DEPTH = 63
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    input  logic              tx_ready,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_end,
    output logic              rx_ready
);
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

    reg_sel_e          sel;
    logic              send_req, send_accept, setup_wr, pop, push;
    logic              busy, sending, waiting, done, last_taken;
    logic              fifo_full, fifo_empty;
    logic [BYTE_W-1:0] fifo_head;
    logic [CNT_W-1:0]  fifo_count;

    assign sel      = reg_sel_e'(reg_addr);
    assign send_req = reg_wr && (sel == SEL_CTRL) && reg_wdata[0];
    assign setup_wr = reg_wr && (sel == SEL_SETUP) && !busy;
    assign pop      = reg_rd && (sel == SEL_DATA);
    assign rx_ready = waiting && !fifo_full;
    assign push     = rx_valid && rx_ready;

    lens_link_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .send_req    (send_req),
        .last_taken  (last_taken),
        .rx_end      (rx_end),
        .send_accept (send_accept),
        .busy        (busy),
        .sending     (sending),
        .waiting     (waiting),
        .done        (done)
    );

    lens_cmd_buf #(.W(BYTE_W), .SLOTS(CMD_LEN)) u_cmd (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (setup_wr),
        .wr_data    (reg_wdata),
        .restart    (send_accept),
        .sending    (sending),
        .tx_ready   (tx_ready),
        .tx_valid   (tx_valid),
        .tx_data    (tx_data),
        .last_taken (last_taken)
    );

    lens_reply_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .flush     (send_accept),
        .push      (push),
        .push_data (rx_data),
        .pop       (pop),
        .head      (fifo_head),
        .count     (fifo_count),
        .full      (fifo_full),
        .empty     (fifo_empty)
    );

    always_comb begin
        unique case (sel)
            SEL_CTRL: reg_rdata = pack_ctrl(CNT_FLD'(fifo_count), done);
            SEL_DATA: reg_rdata = fifo_head;
            default:  reg_rdata = '0;
        endcase
    end

    AST_SEND_CLEARS: assert property (@(posedge clk) disable iff (rst)
        send_accept |=> (fifo_count == '0 && !done)) // R5
        else $error("start did not clear count and flag");

    AST_RX_ONLY_WAIT: assert property (@(posedge clk) disable iff (rst)
        push |-> (busy && !sending)) // R6
        else $error("reply byte stored outside the reply phase");

    AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_DATA && fifo_empty) |-> (reg_rdata == '0)) // R8
        else $error("empty data read not zero");

endmodule

// File: tb/tb_lens_mbox.sv
module tb_lens_mbox;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       tx_valid;
    logic [7:0] tx_data;
    logic       tx_ready = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       rx_end = 1'b0;
    logic       rx_ready;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    lens_mbox dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_end(rx_end),
        .rx_ready(rx_ready)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic host_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic load4(input logic [31:0] w);
        for (int i = 0; i < 4; i++) host_write(2'd1, w[8*i +: 8]);
    endtask

    task automatic lens_collect(input bit stall, output logic [31:0] w);
        int got;
        int cyc;
        got = 0; cyc = 0; w = '0;
        while (got < 4 && cyc < 100) begin
            @(negedge clk);
            tx_ready = stall ? cyc[0] : 1'b1;
            #1;
            if (tx_valid && tx_ready) begin
                w[8*got +: 8] = tx_data;
                got++;
            end
            cyc++;
        end
        @(negedge clk);
        tx_ready = 1'b0;
    endtask

    task automatic lens_reply(input int n, input logic [7:0] base, input bit merge);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_data = base + 8'(i);
            rx_end = merge && (i == n - 1);
        end
        @(negedge clk);
        rx_valid = 1'b0;
        if (merge && n > 0) begin
            rx_end = 1'b0;
        end else begin
            rx_end = 1'b1;
            @(negedge clk);
            rx_end = 1'b0;
        end
    endtask

    task automatic t_reset;
        logic [7:0] d;
        host_read(2'd0, d); chk("R1 ctrl after reset", d, 8'h00);
        host_read(2'd2, d); chk("R1 data after reset", d, 8'h00);
        chk("R1 tx_valid low", tx_valid, 1'b0);
        chk("R1 rx_ready low", rx_ready, 1'b0);
        host_read(2'd3, d); chk("R4 unused address", d, 8'h00);
    endtask

    task automatic t_basic;
        logic [31:0] w;
        logic [7:0]  d;
        load4(32'h04030201);
        host_write(2'd0, 8'h01);
        host_read(2'd0, d); chk("R5 ctrl right after start", d, 8'h00);
        lens_collect(1'b0, w); chk("R3 little-endian word", w, 32'h04030201);
        lens_reply(3, 8'hC1, 1'b0);
        chk("R7 idle after end", rx_ready, 1'b0);
        host_read(2'd0, d); chk("R4 count3 done", d, 8'h0E);
        host_read(2'd2, d); chk("R8 first byte", d, 8'hC1);
        host_read(2'd0, d); chk("R8 count after pop", d, 8'h0A);
        host_read(2'd2, d); chk("R8 second byte", d, 8'hC2);
        host_read(2'd2, d); chk("R8 third byte", d, 8'hC3);
        host_read(2'd2, d); chk("R8 empty read", d, 8'h00);
        host_read(2'd0, d); chk("R8 count stays 0", d, 8'h02);
    endtask

    task automatic t_pending;
        logic [31:0] w;
        logic [7:0]  d;
        load4(32'h14131211);
        host_write(2'd0, 8'h01);
        lens_collect(1'b0, w); chk("R3 second command", w, 32'h14131211);
        @(negedge clk); rx_valid = 1'b1; rx_data = 8'h33;
        #1 chk("R6 ready while waiting", rx_ready, 1'b1);
        @(negedge clk); rx_valid = 1'b0;
        host_read(2'd0, d); chk("R7 no flag before end", d, 8'h04);
        host_write(2'd0, 8'h01);
        host_write(2'd1, 8'hFF);
        @(negedge clk); #1 chk("R9 start ignored while waiting", tx_valid, 1'b0);
        host_read(2'd0, d); chk("R9 count kept while waiting", d, 8'h04);
        lens_reply(1, 8'h5A, 1'b1);
        host_read(2'd0, d); chk("R7 end with byte", d, 8'h0A);
        host_read(2'd2, d); chk("R8 fifo order", d, 8'h33);
        host_read(2'd2, d); chk("R7 byte merged with end", d, 8'h5A);
    endtask

    task automatic t_pointer;
        logic [31:0] w;
        host_write(2'd1, 8'h21); host_write(2'd1, 8'h22); host_write(2'd1, 8'h23);
        host_write(2'd0, 8'h01);
        lens_collect(1'b1, w); chk("R9 busy setup write dropped", w, 32'h14232221);
        lens_reply(0, 8'h00, 1'b0);
        host_write(2'd1, 8'hAA); host_write(2'd1, 8'hBB);
        host_write(2'd0, 8'h01);
        lens_collect(1'b0, w); chk("R2 partial load keeps old slots", w, 32'h1423BBAA);
        lens_reply(0, 8'h00, 1'b0);
        for (int i = 1; i <= 5; i++) host_write(2'd1, 8'(i));
        host_write(2'd0, 8'h01);
        lens_collect(1'b1, w); chk("R2 pointer wraps", w, 32'h04030205);
        lens_reply(0, 8'h00, 1'b0);
    endtask

    task automatic t_clear;
        logic [31:0] w;
        logic [7:0]  d;
        load4(32'hA4A3A2A1);
        host_write(2'd0, 8'h01);
        lens_collect(1'b0, w);
        lens_reply(2, 8'h70, 1'b1);
        host_read(2'd0, d); chk("R7 two bytes done", d, 8'h0A);
        host_write(2'd0, 8'h01);
        host_read(2'd0, d); chk("R5 start clears count and flag", d, 8'h00);
        lens_collect(1'b0, w); chk("R3 resend same slots", w, 32'hA4A3A2A1);
        lens_reply(0, 8'h00, 1'b0);
        host_read(2'd0, d); chk("R7 empty reply", d, 8'h02);
        host_read(2'd2, d); chk("R5 old bytes discarded", d, 8'h00);
        @(negedge clk); rx_valid = 1'b1; rx_data = 8'h99;
        #1 chk("R6 not ready while idle", rx_ready, 1'b0);
        @(negedge clk); rx_valid = 1'b0;
        host_read(2'd0, d); chk("R6 idle byte not stored", d, 8'h02);
    endtask

    task automatic t_full;
        logic [31:0] w;
        logic [7:0]  d;
        bit          ok;
        load4(32'h00000001);
        host_write(2'd0, 8'h01);
        lens_collect(1'b0, w);
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_data = 8'h40 + 8'(i);
            #1;
            if (i == 63) chk("R6 ready low when full", rx_ready, 1'b0);
        end
        @(negedge clk); rx_valid = 1'b0; rx_end = 1'b1;
        @(negedge clk); rx_end = 1'b0;
        host_read(2'd0, d); chk("R6 count 63 done", d, 8'hFE);
        ok = 1'b1;
        for (int i = 0; i < 63; i++) begin
            host_read(2'd2, d);
            if (d !== 8'h40 + 8'(i)) ok = 1'b0;
        end
        chk("R8 drain of full fifo in order", ok, 1'b1);
        host_read(2'd2, d); chk("R6 byte beyond 63 not stored", d, 8'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_basic;
        t_pending;
        t_pointer;
        t_clear;
        t_full;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule